// File: doc/BRIEF.md
# Line Drop Compensation Calculator

This block projects the voltage a regulator should act on to the load center. Each valid sample carries a signed voltage reading plus the in-phase and quadrature parts of the load current. The block scales the in-phase part by a resistance setting and the quadrature part by a reactance setting. It gives each of those two terms the sign chosen by a polarity selector. It then subtracts the resulting simulated line drop from the measured voltage. The result is registered and reported with a valid flag one clock later.

The selector has three active polarity settings and an off setting. The off setting passes the measured voltage through unchanged, which is useful for testing without disturbing the stored settings. Wye-connected four-wire service uses the setting with both terms positive. The two settings that reverse one term exist for delta service, where the line current is displaced from the line-to-line voltage. The resistance, reactance and selector values are sampled together with each valid sample, so a change applies from the next valid sample onward.

Top module: `ldc_compensator`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first valid sample, `out_valid` is 0 and `v_out` is 0.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and it is low otherwise.
- R3: With `pol_sel` = 2'b01 (both terms positive), `v_out` = `v_in` − floor(`r_set`·`i_p`/256) − floor(`x_set`·`i_q`/256). The division by 256 is an arithmetic right shift by 8 bits, and `r_set` and `x_set` are unsigned.
- R4: With `pol_sel` = 2'b10 (reactance term negative), the reactance term is added instead of subtracted, while the resistance term is still subtracted.
- R5: With `pol_sel` = 2'b11 (resistance term negative), the resistance term is added instead of subtracted, while the reactance term is still subtracted.
- R6: With `pol_sel` = 2'b00 (off), `v_out` equals `v_in`, whatever `r_set`, `x_set`, `i_p` and `i_q` are.
- R7: A result above 32767 is output as 32767, and a result below −32768 is output as −32768. The output never wraps.
- R8: In a cycle with `in_valid` low, the block ignores its sample and setting inputs. `v_out` keeps the value it held before.
- R9: A new `r_set`, `x_set` or `pol_sel` value applies to the valid sample presented in the same cycle. Earlier results are not changed.
- R10: With `r_set` and `x_set` both 0, `v_out` equals `v_in` under every `pol_sel` value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe that marks a valid voltage and current sample |
| v_in | input | 16 | Measured voltage, signed |
| i_p | input | 16 | In-phase load current, signed |
| i_q | input | 16 | Quadrature load current, signed |
| r_set | input | 8 | Resistance setting, unsigned |
| x_set | input | 8 | Reactance setting, unsigned |
| pol_sel | input | 2 | 00 off, 01 +X+R, 10 −X+R, 11 +X−R |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| v_out | output | 16 | Compensated voltage, signed and saturated |

## Verification
The assertions check on every cycle that the valid flag tracks the strobe with one cycle of delay. They also check that the result holds in idle cycles, that the off setting passes the voltage through, and that zero settings leave the voltage unchanged. Only the bench scenarios can show the signed arithmetic: the sign each polarity setting gives each term, the floor rounding of negative products, clamping at both ends of the range, and settings that change between consecutive samples.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

  typedef enum logic [1:0] {
    POL_OFF   = 2'b00,
    POL_PXPR  = 2'b01,
    POL_NXPR  = 2'b10,
    POL_PXNR  = 2'b11
  } ldc_pol_e;

  typedef struct packed {
    logic bypass;
    logic neg_r;
    logic neg_x;
  } ldc_ctl_t;

  function automatic ldc_ctl_t ldc_decode(input logic [1:0] sel);
    ldc_ctl_t c;
    c = '0;
    unique case (ldc_pol_e'(sel))
      POL_OFF:  c.bypass = 1'b1;
      POL_PXPR: c = '0;
      POL_NXPR: c.neg_x  = 1'b1;
      POL_PXNR: c.neg_r  = 1'b1;
      default:  c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ldc_drop_term.sv
module ldc_drop_term #(
  parameter int CUR_W = 16,
  parameter int SET_W = 8,
  parameter int SHIFT = 8,
  localparam int PROD_W = CUR_W + SET_W + 1,
  localparam int TERM_W = PROD_W - SHIFT + 1
) (
  input  logic                     neg,
  input  logic [SET_W-1:0]         coef,
  input  logic signed [CUR_W-1:0]  cur,
  output logic signed [TERM_W-1:0] term
);

  logic signed [PROD_W-1:0]         prod;
  logic signed [PROD_W-1:0]         scaled;
  logic signed [PROD_W-SHIFT-1:0]   trimmed;

  always_comb begin
    prod    = PROD_W'($signed({1'b0, coef})) * PROD_W'(cur);
    scaled  = prod >>> SHIFT;
    trimmed = $signed(scaled[PROD_W-SHIFT-1:0]);
    if (neg) begin
      term = -TERM_W'(trimmed);
    end else begin
      term = TERM_W'(trimmed);
    end
  end

endmodule

// File: rtl/ldc_saturate.sv
module ldc_saturate #(
  parameter int IN_W  = 20,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);

  localparam logic signed [IN_W-1:0] MAXV = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MINV = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (din > MAXV) begin
      dout = MAXV[OUT_W-1:0];
    end else if (din < MINV) begin
      dout = MINV[OUT_W-1:0];
    end else begin
      dout = din[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/ldc_compensator.sv
module ldc_compensator #(
  parameter int V_W   = 16,
  parameter int CUR_W = 16,
  parameter int SET_W = 8,
  parameter int SHIFT = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [V_W-1:0]   v_in,
  input  logic signed [CUR_W-1:0] i_p,
  input  logic signed [CUR_W-1:0] i_q,
  input  logic [SET_W-1:0]        r_set,
  input  logic [SET_W-1:0]        x_set,
  input  logic [1:0]              pol_sel,
  output logic                    out_valid,
  output logic signed [V_W-1:0]   v_out
);
  import ldc_pkg::*;

  localparam int NTERM  = 2;
  localparam int PROD_W = CUR_W + SET_W + 1;
  localparam int TERM_W = PROD_W - SHIFT + 1;
  localparam int DROP_W = TERM_W + 1;
  localparam int ACC_W  = ((DROP_W > V_W) ? DROP_W : V_W) + 1;

  ldc_ctl_t                  ctl;
  logic [SET_W-1:0]          coef [NTERM];
  logic signed [CUR_W-1:0]   cur  [NTERM];
  logic                      neg  [NTERM];
  logic signed [TERM_W-1:0]  term [NTERM];
  logic signed [DROP_W-1:0]  drop;
  logic signed [ACC_W-1:0]   acc;
  logic signed [V_W-1:0]     sat_val;
  logic signed [V_W-1:0]     v_nxt;
  logic                      vld_nxt;

  always_comb begin
    ctl     = ldc_decode(pol_sel);
    coef[0] = r_set;
    cur[0]  = i_p;
    neg[0]  = ctl.neg_r;
    coef[1] = x_set;
    cur[1]  = i_q;
    neg[1]  = ctl.neg_x;
  end

  for (genvar g = 0; g < NTERM; g++) begin : g_term
    ldc_drop_term #(
      .CUR_W (CUR_W),
      .SET_W (SET_W),
      .SHIFT (SHIFT)
    ) u_term (
      .neg  (neg[g]),
      .coef (coef[g]),
      .cur  (cur[g]),
      .term (term[g])
    );
  end

  always_comb begin
    drop = DROP_W'(term[0]) + DROP_W'(term[1]);
    if (ctl.bypass) begin
      acc = ACC_W'(v_in);
    end else begin
      acc = ACC_W'(v_in) - ACC_W'(drop);
    end
  end

  ldc_saturate #(
    .IN_W  (ACC_W),
    .OUT_W (V_W)
  ) u_sat (
    .din  (acc),
    .dout (sat_val)
  );

  // next-state
  always_comb begin
    vld_nxt = in_valid;
    v_nxt   = v_out;
    if (in_valid) begin
      v_nxt = sat_val;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      v_out     <= '0;
    end else begin
      out_valid <= vld_nxt;
      v_out     <= v_nxt;
    end
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> $stable(v_out));

  // R6
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && ($past(pol_sel) == 2'b00)) |-> (v_out == $past(v_in)));

  // R10
  zero_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && ($past(r_set) == '0) && ($past(x_set) == '0))
      |-> (v_out == $past(v_in)));

endmodule

// File: tb/tb_ldc_compensator.sv
module tb_ldc_compensator;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic signed [15:0] v_in;
  logic signed [15:0] i_p;
  logic signed [15:0] i_q;
  logic [7:0]         r_set;
  logic [7:0]         x_set;
  logic [1:0]         pol_sel;
  logic               out_valid;
  logic signed [15:0] v_out;

  int checks = 0;
  int failures = 0;

  ldc_compensator dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .v_in(v_in),
    .i_p(i_p), .i_q(i_q), .r_set(r_set), .x_set(x_set),
    .pol_sel(pol_sel), .out_valid(out_valid), .v_out(v_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int model(int v, int ip, int iq, int r, int x, int sel);
    longint tr, tx, res;
    tr = (longint'(r) * longint'(ip)) >>> 8;
    tx = (longint'(x) * longint'(iq)) >>> 8;
    case (sel)
      0: res = v;
      1: res = v - tr - tx;
      2: res = v - tr + tx;
      default: res = v + tr - tx;
    endcase
    if (res > 32767) res = 32767;
    if (res < -32768) res = -32768;
    return int'(res);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one valid sample at a falling edge, check the result one cycle later
  task automatic sample(string req, int v, int ip, int iq, int r, int x, int sel);
    int exp;
    exp = model(v, ip, iq, r, x, sel);
    @(negedge clk);
    in_valid = 1'b1;
    v_in = 16'(v); i_p = 16'(ip); i_q = 16'(iq);
    r_set = 8'(r); x_set = 8'(x); pol_sel = 2'(sel);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, int'(v_out), exp);
    check({req, " valid"}, int'(out_valid), 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; v_in = '0; i_p = '0; i_q = '0;
    r_set = '0; x_set = '0; pol_sel = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 value in reset", int'(v_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after release", int'(out_valid), 0);
    check("R1 value after release", int'(v_out), 0);
  endtask

  task automatic t_wye();
    sample("R3 positive", 12000, 1000, 500, 64, 32, 1);
    sample("R3 negative currents", 9000, -1000, -777, 3, 201, 1);
    sample("R3 mixed", -5000, 4321, -2100, 255, 17, 1);
  endtask

  task automatic t_negx();
    sample("R4 reactance reversed", 12000, 1000, 500, 64, 32, 2);
    sample("R4 negative current", 7000, -3000, -2500, 90, 120, 2);
  endtask

  task automatic t_negr();
    sample("R5 resistance reversed", 12000, 1000, 500, 64, 32, 3);
    sample("R5 negative current", -7000, -3000, 2500, 200, 40, 3);
  endtask

  task automatic t_bypass();
    sample("R6 off large settings", 11111, 30000, -30000, 255, 255, 0);
    sample("R6 off negative", -20000, -5, 5, 7, 9, 0);
  endtask

  task automatic t_sat();
    sample("R7 clamp high", 32000, -32768, 0, 255, 0, 1);
    check("R7 clamp high value", int'(v_out), 32767);
    sample("R7 clamp low", -32000, 32767, 0, 255, 0, 1);
    check("R7 clamp low value", int'(v_out), -32768);
  endtask

  task automatic t_hold();
    int held;
    sample("R8 setup", 15000, 2000, 1000, 100, 50, 1);
    held = int'(v_out);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      v_in = 16'(k * 1234 - 3000); i_p = 16'(k * 999); i_q = 16'(-k * 555);
      r_set = 8'(k * 60); x_set = 8'(255 - k); pol_sel = 2'(k);
      check("R8 hold value", int'(v_out), held);
      check("R8 valid low", int'(out_valid), 0);
    end
  endtask

  task automatic t_change();
    int e1, e2;
    e1 = model(10000, 2000, 1000, 40, 80, 1);
    e2 = model(10000, 2000, 1000, 200, 10, 3);
    @(negedge clk);
    in_valid = 1'b1; v_in = 16'(10000); i_p = 16'(2000); i_q = 16'(1000);
    r_set = 8'(40); x_set = 8'(80); pol_sel = 2'(1);
    @(negedge clk);
    check("R9 first sample", int'(v_out), e1);
    r_set = 8'(200); x_set = 8'(10); pol_sel = 2'(3);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second sample new settings", int'(v_out), e2);
  endtask

  task automatic t_zero();
    for (int s = 0; s < 4; s++) begin
      sample("R10 zero settings", 3210 - s * 5000, 12345, -23456, 0, 0, s);
      check("R10 equals input", int'(v_out), 3210 - s * 5000);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_wye();
    t_negx();
    t_negr();
    t_bypass();
    t_sat();
    t_hold();
    t_change();
    t_zero();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule